// File: doc/BRIEF.md
# Interrupt Status Register with Normal and Abnormal Summaries

This block holds the 32-bit interrupt and status word of a network controller. Event strobes from the transmit and receive machinery, the timer and the bus interface each raise one sticky bit. The host clears bits by writing ones to them. Zeros in the written word leave the matching bits alone. Two summary bits are derived from fixed groups of the sticky bits, and a level interrupt is raised whenever either summary is set.

The read value is built combinationally each cycle. The two summary positions always show the current summaries. Two 3-bit process-state fields show the run state of the receive and transmit engines. Their run-enable inputs OR a fixed code into them, and nothing about the run state is stored. Address decode happens outside, so the block sees only a write strobe with a data word and presents its read word at all times.

Top module: `irq_status_reg`

## Requirements
- R1: After a synchronous active-low reset the stored word is 0xFC000000. With both run inputs low the read word is 0xFC000000 and the interrupt output is low.
- R2: An event strobe on an implemented bit position sets that bit from the next clock edge. The bit stays set until the host clears it. The implemented positions are 0, 1, 2, 3, 5, 6, 7, 8, 9, 11 and 13.
- R3: Event strobes on any other bit position have no effect on the read word or on the interrupt.
- R4: A host write clears every stored bit whose position is 1 in the written word, including the reset-set bits 31 to 26. Bits written as 0 keep their value.
- R5: When an event strobe and a host write address the same bit in the same cycle, the bit ends up set.
- R6: Read bit 16 (normal summary) is 1 exactly when any of stored bits 0, 2 or 6 is set.
- R7: Read bit 15 (abnormal summary) is 1 exactly when any of stored bits 1, 3, 5, 7, 8, 9, 11 or 13 is set.
- R8: Writes to positions 15 and 16 leave no lasting trace. The read word shows only the recomputed summaries there.
- R9: The interrupt output is high exactly when read bit 15 or read bit 16 is 1.
- R10: In the same cycle, receive-run high ORs binary 011 into read bits 19:17. Transmit-run high ORs binary 011 into read bits 22:20. Both inputs low leave those fields as stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 32 | Per-bit event strobes, one cycle each |
| wr_en | input | 1 | Host write strobe for this register |
| wr_data | input | 32 | Host write word, ones clear bits |
| rx_run | input | 1 | Receive engine running |
| tx_run | input | 1 | Transmit engine running |
| rd_data | output | 32 | Composed read word |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can meet in one cycle: a hardware event setting a bit and a host write clearing it. The bench drives both at once on the same bit, and also on neighbouring bits, both in directed steps and in a long pseudo-random stream. A behavioural model applies "clear, then set" for each cycle. The read word and the interrupt are compared against that model after every edge, so any case where the clear wins, or where the summaries lag the stored bits, shows up as a mismatch.

// File: rtl/irq_stat_pkg.sv
// Shared constants for the interrupt status register.
// Assumes a 32-bit register with fixed summary and run-field positions.
package irq_stat_pkg;
    localparam int REG_W = 32;
    // Positions an event may set: 0,1,2,3,5,6,7,8,9,11,13
    localparam logic [REG_W-1:0] SET_MASK_DEF = 32'h0000_2BEF;
    // Normal group: 0,2,6
    localparam logic [REG_W-1:0] NRM_MASK_DEF = 32'h0000_0045;
    // Abnormal group: 1,3,5,7,8,9,11,13
    localparam logic [REG_W-1:0] ABN_MASK_DEF = 32'h0000_2BAA;
    localparam logic [REG_W-1:0] RST_VAL_DEF  = 32'hFC00_0000;
    localparam int ABN_POS_DEF = 15;
    localparam int NRM_POS_DEF = 16;
    localparam int RXF_LSB_DEF = 17;
    localparam int TXF_LSB_DEF = 20;
    localparam int FLD_W_DEF   = 3;
    localparam logic [FLD_W_DEF-1:0] RUN_CODE_DEF = 3'd3;
endpackage

// File: rtl/irq_stat_bits.sv
// Sticky status storage, one flop per bit.
// Each bit is set by a masked event strobe and cleared by a host write of 1.
// When both act in one cycle the set wins.
// Assumes event strobes are synchronous to clk.
module irq_stat_bits #(
    parameter int W = 32,
    parameter logic [W-1:0] SET_MASK = '0,
    parameter logic [W-1:0] RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_en,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] set_req;
    logic [W-1:0] clr_req;

    // Qualify strobes: only implemented positions may set, only writes clear.
    always_comb begin
        set_req = evt_i & SET_MASK;
        clr_req = clr_en ? clr_i : '0;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic q;

        // Per-bit update with set taking priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          q <= RST_VAL[i];
            else if (set_req[i]) q <= 1'b1;
            else if (clr_req[i]) q <= 1'b0;
        end

        assign stat_o[i] = q;

        // R5: a set request always leaves the bit set
        a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_req[i] |=> stat_o[i]);
        // R4: a clear without a set leaves the bit clear
        a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[i] && !set_req[i]) |=> !stat_o[i]);
        // R2: without set or clear the bit holds
        a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_req[i] && !clr_req[i]) |=> $stable(stat_o[i]));
    end
endmodule

// File: rtl/irq_stat_summary.sv
// Summary and interrupt logic.
// Reduces the stored bits over the normal and abnormal groups and drives a
// level interrupt from either result. Purely combinational.
module irq_stat_summary #(
    parameter int W = 32,
    parameter logic [W-1:0] NRM_MASK = '0,
    parameter logic [W-1:0] ABN_MASK = '0
) (
    input  logic [W-1:0] stat_i,
    output logic         nrm_o,
    output logic         abn_o,
    output logic         irq_o
);
    // Group reductions and interrupt level.
    always_comb begin
        nrm_o = |(stat_i & NRM_MASK);
        abn_o = |(stat_i & ABN_MASK);
        irq_o = nrm_o | abn_o;
    end
endmodule

// File: rtl/irq_stat_readmux.sv
// Read word composer.
// Replaces the summary positions with the live summaries and ORs the run code
// into the receive and transmit state fields when their engines run.
// Assumes the fields fit inside the register.
module irq_stat_readmux #(
    parameter int W       = 32,
    parameter int ABN_POS = 15,
    parameter int NRM_POS = 16,
    parameter int RXF_LSB = 17,
    parameter int TXF_LSB = 20,
    parameter int FLD_W   = 3,
    parameter logic [FLD_W-1:0] RUN_CODE = 3'd3
) (
    input  logic [W-1:0] stat_i,
    input  logic         nrm_i,
    input  logic         abn_i,
    input  logic         rx_run,
    input  logic         tx_run,
    output logic [W-1:0] rd_o
);
    // Compose the visible word from stored bits, summaries and run state.
    always_comb begin
        rd_o          = stat_i;
        rd_o[ABN_POS] = abn_i;
        rd_o[NRM_POS] = nrm_i;
        if (rx_run) rd_o[RXF_LSB +: FLD_W] = stat_i[RXF_LSB +: FLD_W] | RUN_CODE;
        if (tx_run) rd_o[TXF_LSB +: FLD_W] = stat_i[TXF_LSB +: FLD_W] | RUN_CODE;
    end
endmodule

// File: rtl/irq_status_reg.sv
// Top: interrupt status register with summaries and run-state overlay.
// Address decode is done outside; wr_en is the decoded write strobe.
// The read word is combinational and reading has no side effects.
module irq_status_reg
    import irq_stat_pkg::*;
#(
    parameter int W = REG_W,
    parameter logic [W-1:0] SET_MASK = SET_MASK_DEF,
    parameter logic [W-1:0] NRM_MASK = NRM_MASK_DEF,
    parameter logic [W-1:0] ABN_MASK = ABN_MASK_DEF,
    parameter logic [W-1:0] RST_VAL  = RST_VAL_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rx_run,
    input  logic         tx_run,
    output logic [W-1:0] rd_data,
    output logic         irq_o
);
    localparam int RXF_MSB = RXF_LSB_DEF + FLD_W_DEF - 1;
    localparam int TXF_MSB = TXF_LSB_DEF + FLD_W_DEF - 1;

    logic [W-1:0] stat_w;
    logic         nrm_w;
    logic         abn_w;

    irq_stat_bits #(.W(W), .SET_MASK(SET_MASK), .RST_VAL(RST_VAL)) u_bits (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .clr_en(wr_en), .clr_i(wr_data), .stat_o(stat_w)
    );

    irq_stat_summary #(.W(W), .NRM_MASK(NRM_MASK), .ABN_MASK(ABN_MASK)) u_sum (
        .stat_i(stat_w), .nrm_o(nrm_w), .abn_o(abn_w), .irq_o(irq_o)
    );

    irq_stat_readmux #(
        .W(W), .ABN_POS(ABN_POS_DEF), .NRM_POS(NRM_POS_DEF),
        .RXF_LSB(RXF_LSB_DEF), .TXF_LSB(TXF_LSB_DEF),
        .FLD_W(FLD_W_DEF), .RUN_CODE(RUN_CODE_DEF)
    ) u_rd (
        .stat_i(stat_w), .nrm_i(nrm_w), .abn_i(abn_w),
        .rx_run(rx_run), .tx_run(tx_run), .rd_o(rd_data)
    );

    // R1: first cycle out of reset shows the reset word
    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat_w == RST_VAL));
    // R9: interrupt level agrees with the visible summaries
    a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (rd_data[ABN_POS_DEF] | rd_data[NRM_POS_DEF]));
    // R10: receive run code visible while receive runs
    a_r10_rx_field: assert property (@(posedge clk) disable iff (!rst_n)
        rx_run |-> ((rd_data[RXF_MSB:RXF_LSB_DEF] & RUN_CODE_DEF) == RUN_CODE_DEF));
    // R10: transmit run code visible while transmit runs
    a_r10_tx_field: assert property (@(posedge clk) disable iff (!rst_n)
        tx_run |-> ((rd_data[TXF_MSB:TXF_LSB_DEF] & RUN_CODE_DEF) == RUN_CODE_DEF));
endmodule

// File: tb/sim_irq_status_reg.sv
`timescale 1ns/1ps
module sim_irq_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rx_run = 1'b0;
    logic        tx_run = 1'b0;
    logic [31:0] rd_data;
    logic        irq_o;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;
    logic [31:0] m_stat;

    localparam logic [31:0] IMPL = 32'h0000_2BEF;
    localparam logic [31:0] NGRP = 32'h0000_0045;
    localparam logic [31:0] AGRP = 32'h0000_2BAA;

    always #4 clk = ~clk;

    irq_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .wr_data(wr_data), .rx_run(rx_run), .tx_run(tx_run),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic [31:0] exp_read(logic [31:0] s, logic rx, logic tx);
        logic [31:0] r;
        r = s;
        r[15] = |(s & AGRP);
        r[16] = |(s & NGRP);
        if (rx) r[18:17] = 2'b11;
        if (tx) r[21:20] = 2'b11;
        return r;
    endfunction

    task automatic compare(input string tag);
        logic [31:0] er;
        logic ei;
        er = exp_read(m_stat, rx_run, tx_run);
        ei = er[15] | er[16];
        nchk++;
        if (rd_data !== er) begin
            nerr++;
            $display("FAIL %s read: actual %h expected %h", tag, rd_data, er);
        end
        nchk++;
        if (irq_o !== ei) begin
            nerr++;
            $display("FAIL %s R9 irq: actual %b expected %b", tag, irq_o, ei);
        end
    endtask

    // Apply inputs for one cycle, advance the model, check after the edge.
    task automatic step(input logic [31:0] e, input logic w, input logic [31:0] d,
                        input logic rx, input logic tx, input string tag);
        evt_i = e; wr_en = w; wr_data = d; rx_run = rx; tx_run = tx;
        @(posedge clk);
        if (!rst_n) m_stat = 32'hFC00_0000;
        else        m_stat = (m_stat & ~(w ? d : 32'h0)) | (e & IMPL);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        m_stat = '0;
        @(negedge clk);
        step('0, 1'b0, '0, 1'b0, 1'b0, "R1 reset");
        step('0, 1'b0, '0, 1'b0, 1'b0, "R1 reset");
        rst_n = 1'b1;
        step('0, 1'b0, '0, 1'b0, 1'b0, "R1 after reset");
        // R4: clear the reset-set top bits
        step('0, 1'b1, 32'hFC00_0000, 1'b0, 1'b0, "R4 clear top");
        // R2/R6: transmit done sets normal summary
        step(32'h1, 1'b0, '0, 1'b0, 1'b0, "R2 R6 set bit0");
        step('0, 1'b0, '0, 1'b0, 1'b0, "R2 sticky");
        // R4: writing zeros keeps, writing one clears
        step('0, 1'b1, 32'h0000_0002, 1'b0, 1'b0, "R4 zero keeps");
        step('0, 1'b1, 32'h0000_0001, 1'b0, 1'b0, "R4 clear bit0");
        // R3: unimplemented positions ignored
        step(~IMPL, 1'b0, '0, 1'b0, 1'b0, "R3 ignored");
        step('0, 1'b0, '0, 1'b0, 1'b0, "R3 ignored hold");
        // R7: fatal bus error drives abnormal summary
        step(32'h2000, 1'b0, '0, 1'b0, 1'b0, "R7 abnormal");
        // R8: writes to summary bits leave no trace
        step('0, 1'b1, 32'h0001_8000, 1'b0, 1'b0, "R8 summary write");
        step(32'h40, 1'b0, '0, 1'b0, 1'b0, "R6 rx done");
        step('0, 1'b1, 32'h0001_8000, 1'b0, 1'b0, "R8 summary write2");
        // R5: set and clear on the same bit in one cycle
        step(32'h2, 1'b1, 32'h2, 1'b0, 1'b0, "R5 set wins");
        step(32'h4, 1'b1, 32'h0000_2046, 1'b0, 1'b0, "R5 mixed");
        // R10: run fields
        step('0, 1'b0, '0, 1'b1, 1'b0, "R10 rx run");
        step('0, 1'b0, '0, 1'b0, 1'b1, "R10 tx run");
        step('0, 1'b0, '0, 1'b1, 1'b1, "R10 both run");
        step('0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R4 clear all");
        // Pseudo-random stream with coincident sets and clears
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = lfsr;
            step(a & b & {b[15:0], a[31:16]}, b[3], a ^ b, a[7], b[9], "R5 random");
        end
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule